// File: doc/BRIEF.md
# Access-Typed Control/Status Register

This block is one control/status register of up to 32 bits. The register is split into fields, and each field follows its own access rule. The rules are read-only, read-write, set-by-one, set-by-one with hardware update, pulse-on-one, write-only, and read-write with hardware update. The register sits on a simple single-cycle register bus with address, write enable, write data, read enable and read data. For each bit it also has hardware-side set, clear, load and load-value inputs. The current contents of every field are driven to the surrounding logic on `value_o`.

The field layout is set by parameters: the LSB, width, access rule, reset value and whether the field is reset. Bits that no field covers are reserved. When a software write and a hardware update hit the same bit of a hardware-updatable field in the same cycle, the hardware update wins. Read data is registered.

Top module: `acc_csr`

## Requirements
- R1: A read-only field (default bits [7:4]) ignores bus writes. It changes only through the hardware inputs, and reads return its stored value.
- R2: A read-write field (default bits [3:0]) stores the written value, and reads return it.
- R3: A set-by-one field (default bits [11:8]) sets each bit written as 1 and keeps each bit written as 0. Hardware inputs do not affect it, and its bits never clear except by reset.
- R4: A set-by-one hardware field (default bits [15:12]) behaves as in R3 and is also updated by the hardware inputs. The hardware update wins over a same-cycle write.
- R5: A pulse field (default bits [19:16]) reads as 0. For each 1 written, the matching `value_o` bit is high for exactly the one cycle after the write.
- R6: A write-only field (default bits [23:20]) reads as 0, and `value_o` holds the last value written to it.
- R7: A read-write hardware field (default bits [27:24]) can be both read and written. A hardware update wins over a same-cycle write.
- R8: Reserved bits (default [31:28]) read as 0, show as 0 on `value_o`, and ignore writes.
- R9: Asynchronous reset loads each field's reset value: bits [3:0]=0x5, bits [27:24]=0xA, and 0 for the other fields. The write-only field is declared without a reset value and keeps its contents across reset.
- R10: `rdata_o` is registered. It shows the readable bits one cycle after `re_i` with a matching address, and is 0 otherwise. A read in the same cycle as a write returns the contents from before the write.
- R11: Writes and reads at any address other than `ADDR` (default 0x10) leave the register unchanged and return 0.
- R12: Hardware inputs have a fixed priority per bit: load (take `hw_val_i`) first, then set, then clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Bus address |
| we_i | input | 1 | Bus write enable |
| wdata_i | input | DW | Bus write data |
| re_i | input | 1 | Bus read enable |
| rdata_o | output | DW | Registered read data |
| hw_set_i | input | DW | Hardware set, per register bit |
| hw_clr_i | input | DW | Hardware clear, per register bit |
| hw_load_i | input | DW | Hardware load enable, per register bit |
| hw_val_i | input | DW | Hardware load value, per register bit |
| value_o | output | DW | Current field contents to local logic |

## Verification
The vector walk starts with an all-ones write and then an all-zeros write. Together these show which fields store data, which accumulate ones, which stay blind to software, and which bits are reserved. A hardware load with no write then shows which fields accept hardware updates. Writes that coincide with hardware clear, set and load show that the hardware wins per bit, and mixed set/clear/load masks show the load-set-clear order. Directed cases cover the single-cycle life of the pulse field, a read racing a write, foreign addresses, and a reset taken mid-run that must leave the unreset write-only field intact.

// File: rtl/regfield_pkg.sv
package regfield_pkg;

  typedef enum logic [2:0] {
    ACC_R    = 3'd0,
    ACC_RW   = 3'd1,
    ACC_RW1  = 3'd2,
    ACC_RW1H = 3'd3,
    ACC_W1   = 3'd4,
    ACC_W    = 3'd5,
    ACC_RWH  = 3'd6
  } acc_e;

  localparam int unsigned DEF_NF = 7;
  localparam int unsigned DEF_LSB [DEF_NF] = '{0, 4, 8, 12, 16, 20, 24};
  localparam int unsigned DEF_WID [DEF_NF] = '{4, 4, 4, 4, 4, 4, 4};
  localparam acc_e DEF_ACC [DEF_NF] =
    '{ACC_RW, ACC_R, ACC_RW1, ACC_RW1H, ACC_W1, ACC_W, ACC_RWH};
  localparam logic [31:0] DEF_RST [DEF_NF] =
    '{32'h5, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hA};
  localparam bit DEF_KNOWN [DEF_NF] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

endpackage

// File: rtl/regfield_hw_mux.sv
module regfield_hw_mux #(
  parameter int unsigned W = 1
) (
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] load_i,
  input  logic [W-1:0] hval_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] nxt_o
);
  // per bit: load > set > clear
  always_comb begin
    for (int b = 0; b < int'(W); b++) begin
      hit_o[b] = load_i[b] | set_i[b] | clr_i[b];
      if (load_i[b])     nxt_o[b] = hval_i[b];
      else if (set_i[b]) nxt_o[b] = 1'b1;
      else               nxt_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/regfield_cell.sv
module regfield_cell
  import regfield_pkg::*;
#(
  parameter int unsigned W         = 1,
  parameter acc_e        ACC       = ACC_RW,
  parameter logic [W-1:0] RST      = '0,
  parameter bit          RST_KNOWN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wd_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] load_i,
  input  logic [W-1:0] hval_i,
  output logic [W-1:0] val_o,
  output logic [W-1:0] rd_o
);
  localparam bit HW_EN = (ACC == ACC_R) || (ACC == ACC_RW1H) || (ACC == ACC_RWH);
  localparam bit RD_EN = (ACC != ACC_W1) && (ACC != ACC_W);

  logic [W-1:0] q, d, sw_d, hw_hit, hw_nxt, hw_take;

  regfield_hw_mux #(.W(W)) u_hw (
    .set_i (set_i),
    .clr_i (clr_i),
    .load_i(load_i),
    .hval_i(hval_i),
    .hit_o (hw_hit),
    .nxt_o (hw_nxt)
  );

  assign hw_take = HW_EN ? hw_hit : '0;

  always_comb begin
    unique case (ACC)
      ACC_RW, ACC_W, ACC_RWH: sw_d = wr_i ? wd_i : q;
      ACC_RW1, ACC_RW1H:      sw_d = q | (wr_i ? wd_i : '0);
      ACC_W1:                 sw_d = wr_i ? wd_i : '0;
      default:                sw_d = q;
    endcase
    d = (hw_take & hw_nxt) | (~hw_take & sw_d);
  end

  if (RST_KNOWN) begin : g_rst
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST;
      else         q <= d;
    end
  end else begin : g_norst
    always_ff @(posedge clk_i) q <= d;
  end

  assign val_o = q;
  assign rd_o  = RD_EN ? q : '0;
endmodule

// File: rtl/acc_csr.sv
module acc_csr
  import regfield_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] ADDR = 8'h10,
  parameter int unsigned NF = DEF_NF,
  parameter int unsigned F_LSB [NF] = DEF_LSB,
  parameter int unsigned F_WID [NF] = DEF_WID,
  parameter acc_e        F_ACC [NF] = DEF_ACC,
  parameter logic [31:0] F_RST [NF] = DEF_RST,
  parameter bit          F_KNOWN [NF] = DEF_KNOWN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] hw_set_i,
  input  logic [DW-1:0] hw_clr_i,
  input  logic [DW-1:0] hw_load_i,
  input  logic [DW-1:0] hw_val_i,
  output logic [DW-1:0] value_o
);
  logic          sel, wr_hit, rd_hit;
  logic [DW-1:0] val_arr [NF];
  logic [DW-1:0] rd_arr  [NF];
  logic [DW-1:0] rd_vis;

  assign sel    = (addr_i == ADDR);
  assign wr_hit = we_i & sel;
  assign rd_hit = re_i & sel;

  for (genvar g = 0; g < int'(NF); g++) begin : g_fld
    localparam int unsigned FL = F_LSB[g];
    localparam int unsigned FW = F_WID[g];
    logic [FW-1:0] f_val, f_rd;

    regfield_cell #(
      .W        (FW),
      .ACC      (F_ACC[g]),
      .RST      (F_RST[g][FW-1:0]),
      .RST_KNOWN(F_KNOWN[g])
    ) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (wr_hit),
      .wd_i  (wdata_i[FL +: FW]),
      .set_i (hw_set_i[FL +: FW]),
      .clr_i (hw_clr_i[FL +: FW]),
      .load_i(hw_load_i[FL +: FW]),
      .hval_i(hw_val_i[FL +: FW]),
      .val_o (f_val),
      .rd_o  (f_rd)
    );

    assign val_arr[g] = DW'(f_val) << FL;
    assign rd_arr[g]  = DW'(f_rd) << FL;
  end

  // uncovered bits stay 0 on both views
  always_comb begin
    value_o = '0;
    rd_vis  = '0;
    for (int i = 0; i < int'(NF); i++) begin
      value_o = value_o | val_arr[i];
      rd_vis  = rd_vis | rd_arr[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_hit ? rd_vis : '0;
  end
endmodule

// File: rtl/regfield_chk.sv
module regfield_chk
  import regfield_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] ADDR = 8'h10,
  parameter int unsigned NF = DEF_NF,
  parameter int unsigned F_LSB [NF] = DEF_LSB,
  parameter int unsigned F_WID [NF] = DEF_WID,
  parameter acc_e        F_ACC [NF] = DEF_ACC
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          we_i,
  input logic          re_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] hw_set_i,
  input logic [DW-1:0] hw_clr_i,
  input logic [DW-1:0] hw_load_i,
  input logic [DW-1:0] hw_val_i,
  input logic [DW-1:0] value_o
);
  function automatic logic [DW-1:0] mask_of(input bit any, input acc_e a);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < int'(NF); i++)
      if (any || F_ACC[i] == a)
        m = m | (((64'd1 << F_WID[i]) - 64'd1) << F_LSB[i]);
    return m[DW-1:0];
  endfunction

  localparam logic [DW-1:0] COVER_M = mask_of(1'b1, ACC_R);
  localparam logic [DW-1:0] R_M     = mask_of(1'b0, ACC_R);
  localparam logic [DW-1:0] RW1_M   = mask_of(1'b0, ACC_RW1);
  localparam logic [DW-1:0] W1_M    = mask_of(1'b0, ACC_W1);
  localparam logic [DW-1:0] W_M     = mask_of(1'b0, ACC_W);
  localparam logic [DW-1:0] RWH_M   = mask_of(1'b0, ACC_RWH);

  assert_rdata_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(re_i && addr_i == ADDR) |=> rdata_o == '0);

  assert_rsvd_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o | value_o) & ~COVER_M) == '0);

  assert_wo_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & (W1_M | W_M)) == '0);

  assert_rw1_no_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(value_o) & ~value_o & RW1_M) == '0));

  assert_w1_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR) |=> (value_o & W1_M) == '0);

  assert_rwh_hw_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hw_load_i & RWH_M) != '0) |=>
      (((value_o ^ $past(hw_val_i)) & $past(hw_load_i) & RWH_M) == '0));

  assert_ro_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((hw_set_i | hw_clr_i | hw_load_i) & R_M) == '0) |=>
      ((value_o & R_M) == ($past(value_o) & R_M)));
endmodule

bind acc_csr regfield_chk #(
  .DW(DW), .AW(AW), .ADDR(ADDR), .NF(NF),
  .F_LSB(F_LSB), .F_WID(F_WID), .F_ACC(F_ACC)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .re_i     (re_i),
  .rdata_o  (rdata_o),
  .hw_set_i (hw_set_i),
  .hw_clr_i (hw_clr_i),
  .hw_load_i(hw_load_i),
  .hw_val_i (hw_val_i),
  .value_o  (value_o)
);

// File: tb/test_acc_csr.sv
`timescale 1ns/1ps
module test_acc_csr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = 8'h10;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        re_i = 1'b0;
  logic [31:0] rdata_o;
  logic [31:0] hw_set_i = '0, hw_clr_i = '0, hw_load_i = '0, hw_val_i = '0;
  logic [31:0] value_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  acc_csr i_acc_csr (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .re_i(re_i), .rdata_o(rdata_o),
    .hw_set_i(hw_set_i), .hw_clr_i(hw_clr_i), .hw_load_i(hw_load_i),
    .hw_val_i(hw_val_i), .value_o(value_o)
  );

  always #2.5 clk_i = ~clk_i;

  typedef struct packed {
    logic        we;
    logic [31:0] wd;
    logic [31:0] set;
    logic [31:0] clr;
    logic [31:0] load;
    logic [31:0] hval;
    logic [31:0] exp_val;
    logic [31:0] exp_rd;
  } vec_t;

  // layout: [3:0] RW, [7:4] R, [11:8] RW1, [15:12] RW1H, [19:16] pulse,
  // [23:20] write-only, [27:24] RWH, [31:28] reserved
  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0FFF_FF0F, 32'h0F00_FF0F},
    '{1'b1, 32'h0000_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_FF00, 32'h0000_FF00},
    '{1'b0, 32'h0000_0000, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0200_5F70, 32'h0200_5F70},
    '{1'b1, 32'h0F0F_F0FF, 32'h0, 32'h0F00_F0F0, 32'h0, 32'h0, 32'h000F_0F0F, 32'h0000_0F0F},
    '{1'b1, 32'h0000_9000, 32'h0500_0030, 32'h0500_0010, 32'h0, 32'h0, 32'h0500_9F30, 32'h0500_9F30},
    '{1'b1, 32'hA5A5_A5A5, 32'h0000_0030, 32'h0, 32'h0000_00F0, 32'h0000_00C0, 32'h05A5_BFC5, 32'h0500_BFC5},
    '{1'b0, 32'h0000_0000, 32'h0, 32'h00FF_0F0F, 32'h0, 32'h0, 32'h05A0_BFC5, 32'h0500_BFC5}
  };
  localparam string VREQ [NV] = '{"R1 R2 R3 R5 R6 R7 R8", "R2 R3 R6 R7", "R1 R4 R7 R12",
                                  "R1 R4 R7", "R4 R7 R12", "R4 R5 R6 R7 R8 R12", "R2 R3 R5 R6"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic idle();
    we_i = 1'b0; re_i = 1'b0; addr_i = 8'h10;
    hw_set_i = '0; hw_clr_i = '0; hw_load_i = '0; hw_val_i = '0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk_i); idle(); addr_i = a; re_i = 1'b1;
    @(negedge clk_i); re_i = 1'b0; addr_i = 8'h10;
    check(req, rdata_o, exp);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    // R9: reset values; write-only field not yet defined
    check("R9 reset value", value_o & 32'hFF0F_FFFF, 32'h0A00_0005);
    check("R10 rdata reset", rdata_o, 32'h0);
    rst_ni = 1'b1;
    rd_check("R9 reset readback", 8'h10, 32'h0A00_0005);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      idle();
      we_i = VEC[i].we; wdata_i = VEC[i].wd;
      hw_set_i = VEC[i].set; hw_clr_i = VEC[i].clr;
      hw_load_i = VEC[i].load; hw_val_i = VEC[i].hval;
      @(negedge clk_i);
      idle(); re_i = 1'b1;
      check({VREQ[i], " value"}, value_o, VEC[i].exp_val);
      @(negedge clk_i);
      re_i = 1'b0;
      check({VREQ[i], " read"}, rdata_o, VEC[i].exp_rd);
    end

    // R5: pulse lasts exactly one cycle
    @(negedge clk_i); idle(); we_i = 1'b1; wdata_i = 32'h05A9_A5A5;
    @(negedge clk_i); idle();
    check("R5 pulse high", value_o & 32'h000F_0000, 32'h0009_0000);
    @(negedge clk_i);
    check("R5 pulse gone", value_o & 32'h000F_0000, 32'h0);

    // R11: foreign address write and read
    @(negedge clk_i); idle(); addr_i = 8'h14; we_i = 1'b1; wdata_i = 32'h0000_0000;
    @(negedge clk_i); idle();
    check("R11 foreign write", value_o, 32'h05A0_BFC5);
    rd_check("R11 foreign read", 8'h14, 32'h0);

    // R10: read racing a write returns old contents, then new
    @(negedge clk_i); idle(); we_i = 1'b1; re_i = 1'b1; wdata_i = 32'h05A0_0003;
    @(negedge clk_i); idle();
    check("R10 read during write", rdata_o, 32'h0500_BFC5);
    @(negedge clk_i);
    check("R10 rdata idle zero", rdata_o, 32'h0);
    rd_check("R10 read after write", 8'h10, 32'h0500_BFC3);

    // R9: reset mid-run; write-only field keeps 0xA
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check("R9 reset keeps unreset field", value_o, 32'h0AA0_0005);
    rst_ni = 1'b1;
    rd_check("R9 readback after reset", 8'h10, 32'h0A00_0005);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule